// File: doc/BRIEF.md
# Keypad Lock and Two-Step Unlock Controller

This block sits in the path from a keypad event source to the event queue. While the keypad is unlocked, each key event passes through one cycle later with an event interrupt pulse. When the host raises the lock enable, the controller enters a locked state. In that state it blanks key events so they never reach the queue, and it stays there until two programmed events arrive in order. Each unlock pattern holds an event identifier and the press or release state that is required.

An optional mask timer limits how often the host is woken while the keypad is locked. The first blanked event raises one event interrupt and loads the timer. Blanked events that follow are silent until the timer runs down. The timer counts in ticks of a prescaled enable, and a parameter sets the tick period. When the unlock sequence completes, the lock status drops and a lock interrupt pulses. The events that make up the sequence are never forwarded.

The sequencer has three states: `ST_OPEN` (unlocked, pass-through), `ST_ARMED` (locked, waiting for the first unlock event) and `ST_HALF` (locked, first event seen, waiting for the second). The transitions are:
- lock: `ST_OPEN`→`ST_ARMED` on a rising edge of the lock enable.
- first-hit: `ST_ARMED`→`ST_HALF` when the first pattern matches and a second pattern is in use.
- short-unlock: `ST_ARMED`→`ST_OPEN` when the first pattern matches and no second pattern is in use.
- second-hit: `ST_HALF`→`ST_OPEN` when the second pattern matches.
- restart: `ST_HALF`→`ST_ARMED` on any other event.
- release: any locked state→`ST_OPEN` when the lock enable is low.

Top module: `keylock_ctrl`

## Requirements
- R1: After reset, `locked`, `out_valid`, `lock_irq` and `event_irq` are all 0.
- R2: While unlocked, an event presented with `ev_valid` appears on `out_valid`/`out_id`/`out_press` one cycle later, together with a one-cycle `event_irq` pulse.
- R3: A rising edge of `lock_en` sets `locked` to 1 one cycle later. After an unlock, the controller stays unlocked for as long as `lock_en` stays high, and it locks again only after `lock_en` has gone low and then high.
- R4: While locked with `mask_time` = 0, no event is forwarded and `event_irq` stays 0.
- R5: An unlock pattern matches an event only if bits 6:0 equal the event identifier and bit 7 equals `ev_press` (1 = press, 0 = release). An event with the right identifier and the wrong state is treated as an ordinary blanked event.
- R6: While locked, an event that matches `unlock_a`, followed by an event that matches `unlock_b`, clears `locked` and pulses `lock_irq` for one cycle. Neither of the two events is forwarded.
- R7: In `ST_HALF`, any event that does not match `unlock_b` returns the sequence to `ST_ARMED`, so `unlock_a` must be seen again. An event matching `unlock_b` in `ST_ARMED` does not unlock.
- R8: A pattern whose bits 6:0 are 0 is unused. If only one pattern is in use, a single matching event unlocks. If both are unused, no event unlocks. An identifier of 0 never matches.
- R9: While locked with `mask_time` > 0, the first blanked event pulses `event_irq` once and loads the timer with `mask_time`. The timer decrements on each tick, and one tick occurs every `TICK_DIV` cycles. Further blanked events raise no interrupt until the count reaches 0.
- R10: Driving `lock_en` low while locked clears `locked` one cycle later without a `lock_irq` pulse. Events are then forwarded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Key event strobe |
| ev_id | input | ID_W | Key event identifier |
| ev_press | input | 1 | Event state, 1 = press, 0 = release |
| unlock_a | input | ID_W+1 | First unlock pattern: {state, id} |
| unlock_b | input | ID_W+1 | Second unlock pattern: {state, id} |
| lock_en | input | 1 | Lock enable; a rising edge locks the keypad |
| mask_time | input | MT_W | Mask timer length in ticks, 0 = timer off |
| out_valid | output | 1 | Forwarded event strobe toward the queue |
| out_id | output | ID_W | Forwarded event identifier |
| out_press | output | 1 | Forwarded event state |
| locked | output | 1 | 1 while the keypad is locked |
| lock_irq | output | 1 | One-cycle pulse when an unlock completes |
| event_irq | output | 1 | One-cycle event interrupt pulse |

## Verification
The bench targets several faults:
- An intervening event in the half-unlocked state. A design that keeps its progress there would unlock on a stray second pattern.
- The second pattern arriving first. A design that matches the patterns in any order would unlock on it.
- A pattern with the right identifier and the wrong state. A design that ignores bit 7 would unlock.
- A lock enable that stays high after an unlock. A level-triggered design would relock at once.
- Zero-identifier patterns. A design that does not treat them as unused would hang or unlock on key 0.
- The mask window. The bench sends events both inside and after it, so a timer that never loads, or one that never expires, shows up as a missing interrupt or an extra one.

// File: rtl/kl_pkg.sv
package kl_pkg;
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HALF  = 2'd2
    } kl_state_e;

    localparam int KL_NUM_PAT = 2;
endpackage

// File: rtl/kl_key_match.sv
module kl_key_match #(
    parameter int ID_W = 7
) (
    input  logic [ID_W-1:0] ev_id,
    input  logic            ev_press,
    input  logic [ID_W:0]   pattern,
    output logic            used,
    output logic            hit
);
    assign used = |pattern[ID_W-1:0];
    assign hit  = used && (ev_id == pattern[ID_W-1:0]) && (ev_press == pattern[ID_W]);
endmodule

// File: rtl/kl_tick_gen.sv
module kl_tick_gen #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt;
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            always_ff @(posedge clk) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/kl_mask_timer.sv
module kl_mask_timer #(
    parameter int MT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [MT_W-1:0] load_val,
    input  logic            tick,
    output logic            active
);
    logic [MT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (clr)                     count <= '0;
        else if (load)                    count <= load_val;
        else if (tick && count != '0)     count <= count - 1'b1;
    end

    assign active = (count != '0);
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
    import kl_pkg::*;
#(
    parameter int ID_W     = 7,
    parameter int MT_W     = 4,
    parameter int TICK_DIV = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    input  logic [ID_W-1:0] ev_id,
    input  logic            ev_press,
    input  logic [ID_W:0]   unlock_a,
    input  logic [ID_W:0]   unlock_b,
    input  logic            lock_en,
    input  logic [MT_W-1:0] mask_time,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id,
    output logic            out_press,
    output logic            locked,
    output logic            lock_irq,
    output logic            event_irq
);
    kl_state_e state, nxt;

    logic [ID_W:0]          pat  [KL_NUM_PAT];
    logic [KL_NUM_PAT-1:0]  used, hit;

    assign pat[0] = unlock_a;
    assign pat[1] = unlock_b;

    genvar g;
    generate
        for (g = 0; g < KL_NUM_PAT; g++) begin : g_match
            kl_key_match #(.ID_W(ID_W)) u_match (
                .ev_id   (ev_id),
                .ev_press(ev_press),
                .pattern (pat[g]),
                .used    (used[g]),
                .hit     (hit[g])
            );
        end
    endgenerate

    // First step uses pattern A if set, else pattern B alone
    logic first_hit, need_second, second_hit;
    assign first_hit   = used[0] ? hit[0] : hit[1];
    assign need_second = used[0] & used[1];
    assign second_hit  = hit[1];

    logic lock_en_q, lock_rise;
    always_ff @(posedge clk) begin
        if (!rst_n) lock_en_q <= 1'b0;
        else        lock_en_q <= lock_en;
    end
    assign lock_rise = lock_en & ~lock_en_q;

    logic tick, mask_active;

    kl_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // Event classification for the current cycle
    logic is_open, seq_step, seq_done, blanked, fwd, mask_trig;
    assign is_open  = (state == ST_OPEN);
    assign seq_step = ev_valid && lock_en &&
                      (((state == ST_ARMED) && first_hit) ||
                       ((state == ST_HALF) && second_hit));
    assign seq_done = ev_valid && lock_en &&
                      (((state == ST_ARMED) && first_hit && !need_second) ||
                       ((state == ST_HALF) && second_hit));
    assign blanked  = ev_valid && lock_en && !is_open && !seq_step;
    assign fwd      = ev_valid && is_open;
    assign mask_trig = blanked && (mask_time != '0) && !mask_active;

    kl_mask_timer #(.MT_W(MT_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (is_open),
        .load    (mask_trig),
        .load_val(mask_time),
        .tick    (tick),
        .active  (mask_active)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPEN: begin
                if (lock_rise) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (!lock_en)
                    nxt = ST_OPEN;
                else if (ev_valid && first_hit)
                    nxt = need_second ? ST_HALF : ST_OPEN;
            end
            ST_HALF: begin
                if (!lock_en)
                    nxt = ST_OPEN;
                else if (ev_valid)
                    nxt = second_hit ? ST_OPEN : ST_ARMED;
            end
            default: nxt = ST_OPEN;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= '0;
            out_press <= 1'b0;
            lock_irq  <= 1'b0;
            event_irq <= 1'b0;
        end else begin
            out_valid <= fwd;
            if (fwd) begin
                out_id    <= ev_id;
                out_press <= ev_press;
            end
            lock_irq  <= seq_done;
            event_irq <= fwd | mask_trig;
        end
    end

    assign locked = (state != ST_OPEN);
endmodule

// File: rtl/keylock_chk.sv
module keylock_chk (
    input logic clk,
    input logic rst_n,
    input logic lock_en,
    input logic locked,
    input logic out_valid,
    input logic lock_irq,
    input logic event_irq,
    input logic mask_active
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !locked && !out_valid && !lock_irq && !event_irq);

    assert_fwd_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> event_irq);

    assert_lock_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> $past(lock_en));

    assert_no_fwd_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$past(locked));

    assert_unlock_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> !locked && $past(locked));

    assert_unlock_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_irq && out_valid));

    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_active) && $past(locked)) |-> !event_irq);
endmodule

bind keylock_ctrl keylock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_en    (lock_en),
    .locked     (locked),
    .out_valid  (out_valid),
    .lock_irq   (lock_irq),
    .event_irq  (event_irq),
    .mask_active(mask_active)
);

// File: tb/sim_keylock_ctrl.sv
module sim_keylock_ctrl;
    localparam int ID_W = 7;
    localparam int MT_W = 4;
    localparam int TDIV = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_valid = 1'b0;
    logic [ID_W-1:0] ev_id = '0;
    logic            ev_press = 1'b0;
    logic [ID_W:0]   unlock_a = {1'b1, 7'd10};
    logic [ID_W:0]   unlock_b = {1'b0, 7'd20};
    logic            lock_en = 1'b0;
    logic [MT_W-1:0] mask_time = '0;
    logic            out_valid, out_press, locked, lock_irq, event_irq;
    logic [ID_W-1:0] out_id;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    keylock_ctrl #(.ID_W(ID_W), .MT_W(MT_W), .TICK_DIV(TDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_id(ev_id),
        .ev_press(ev_press), .unlock_a(unlock_a), .unlock_b(unlock_b),
        .lock_en(lock_en), .mask_time(mask_time), .out_valid(out_valid),
        .out_id(out_id), .out_press(out_press), .locked(locked),
        .lock_irq(lock_irq), .event_irq(event_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic le, input logic v, input logic p, input int id);
        lock_en  = le;
        ev_valid = v;
        ev_press = p;
        ev_id    = ID_W'(id);
        @(negedge clk);
    endtask

    // {lock_en, ev_valid, press, id[6:0], exp_valid, exp_locked, exp_lock_irq, exp_event_irq}
    localparam logic [13:0] VEC [15] = '{
        14'b0_1_1_0000101_1_0_0_1,  // R2 press 5 forwarded
        14'b0_1_0_0000101_1_0_0_1,  // R2 release 5 forwarded
        14'b1_0_0_0000000_0_1_0_0,  // R3 lock on rising edge
        14'b1_1_1_0000111_0_1_0_0,  // R4 blanked, no irq
        14'b1_1_0_0001010_0_1_0_0,  // R5 right id wrong state
        14'b1_1_1_0001010_0_1_0_0,  // R6 first pattern
        14'b1_1_1_0000011_0_1_0_0,  // R7 stray event restarts
        14'b1_1_0_0010100_0_1_0_0,  // R7 second pattern alone
        14'b1_1_1_0001010_0_1_0_0,  // R6 first pattern again
        14'b1_1_0_0010100_0_0_1_0,  // R6 second pattern unlocks
        14'b1_1_1_0001000_1_0_0_1,  // R3 lock_en held high stays open
        14'b0_0_0_0000000_0_0_0_0,  // R3 lock_en low
        14'b1_0_0_0000000_0_1_0_0,  // R3 relock
        14'b0_0_0_0000000_0_0_0_0,  // R10 drop lock_en unlocks, no irq
        14'b0_1_1_0001001_1_0_0_1   // R10 forwarding resumes
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 locked", int'(locked), 0);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 irqs", int'({lock_irq, event_irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 15; i++) begin
            logic [13:0] v;
            v = VEC[i];
            drive(v[13], v[12], v[11], int'(v[10:4]));
            check($sformatf("vec%0d out_valid", i), int'(out_valid), int'(v[3]));
            check($sformatf("vec%0d locked", i), int'(locked), int'(v[2]));
            check($sformatf("vec%0d lock_irq", i), int'(lock_irq), int'(v[1]));
            check($sformatf("vec%0d event_irq", i), int'(event_irq), int'(v[0]));
            if (v[3]) begin
                check($sformatf("vec%0d R2 out_id", i), int'(out_id), int'(v[10:4]));
                check($sformatf("vec%0d R2 out_press", i), int'(out_press), int'(v[11]));
            end
        end

        // R8: second pattern unused, first alone unlocks
        unlock_b = '0;
        drive(0, 0, 0, 0);
        drive(1, 0, 0, 0);
        check("R8 locked", int'(locked), 1);
        drive(1, 1, 1, 10);
        check("R8 single unlock", int'(locked), 0);
        check("R8 lock_irq", int'(lock_irq), 1);
        check("R8 not forwarded", int'(out_valid), 0);
        // R8: first pattern unused, second alone unlocks
        unlock_a = '0;
        unlock_b = {1'b0, 7'd20};
        drive(0, 0, 0, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 20);
        check("R8 B-only unlock", int'(locked), 0);
        check("R8 B-only lock_irq", int'(lock_irq), 1);
        // R8: both unused, nothing unlocks, id 0 never matches
        unlock_b = '0;
        drive(0, 0, 0, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);
        check("R8 zero id stays locked", int'(locked), 1);
        drive(1, 1, 1, 10);
        check("R8 both unused stays locked", int'(locked), 1);
        check("R8 no lock_irq", int'(lock_irq), 0);

        // R9: mask timer
        unlock_a = {1'b1, 7'd10};
        unlock_b = {1'b0, 7'd20};
        mask_time = 4'd3;
        drive(0, 0, 0, 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 1, 7);
        check("R9 first blanked irq", int'(event_irq), 1);
        check("R9 not forwarded", int'(out_valid), 0);
        drive(1, 1, 1, 7);
        check("R9 masked irq", int'(event_irq), 0);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 7);
        check("R9 still masked", int'(event_irq), 0);
        for (int k = 0; k < 14; k++) drive(1, 0, 0, 0);
        drive(1, 1, 1, 7);
        check("R9 irq after expiry", int'(event_irq), 1);
        drive(1, 1, 1, 10);
        drive(1, 1, 0, 20);
        check("R9 unlock under mask", int'(locked), 0);
        check("R9 lock_irq under mask", int'(lock_irq), 1);
        drive(0, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule